// File: doc/BRIEF.md
# Bipolar Line Code Decoder (B8ZS / HDB3 / AMI)

This block turns one channel of dual-rail bipolar receive data into single-rail NRZ data. Each bit arrives as a positive pulse flag and a negative pulse flag, qualified by a bit enable. The decoder finds bipolar violations and removes the zero-substitution codes that the far end inserted. It uses B8ZS on T1 lines and HDB3 on E1 lines. It can also treat the stream as plain AMI, where every pulse is a one.

The rule comes from a global code-select input. When a per-channel override enable is high, a per-channel code bit chooses the rule instead, for this channel only. A dual-rail mode input bypasses the decoder completely. In that mode the NRZ output stays low, and every code-select input is ignored.

The raw rails are always delayed alongside the decoded data, so the block has the same latency in every mode. A polarity tracker holds the polarity of the last single-rail pulse. It has three states:

- POL_NONE: no pulse seen since reset.
- POL_POS: the last single-rail pulse was positive.
- POL_NEG: the last single-rail pulse was negative.

Tracker transitions happen only on enabled bits:

- From any state, a positive-only pulse moves the tracker to POL_POS.
- From any state, a negative-only pulse moves it to POL_NEG.
- No pulse, or pulses on both rails, keeps the current state.

A violation is flagged when a single-rail pulse arrives in POL_POS with positive polarity, or in POL_NEG with negative polarity.

Top module: `lcd_decoder`

## Requirements
- R1: While rst_n is low, and after its release until the first enabled bit, rd_data, rd_pos and rd_neg are 0 and the tracker is in POL_NONE.
- R2: A symbol presented on an edge with bit_en high appears on the outputs after the eighth following enabled edge. The outputs change only on edges where bit_en is high.
- R3: With the effective code bit at 1 (AMI), rd_data is 1 for any pulse on either rail, including violations, and 0 for no pulse.
- R4: A violation is a single-rail pulse of the same polarity as the last single-rail pulse. The first pulse after reset is never a violation. Pulses on both rails decode as 1, never count as a violation, and leave the tracked polarity unchanged.
- R5: With the effective code bit at 0 and e1_mode at 0 (B8ZS), the eight-bit sequence zero, zero, zero, violation, non-violating pulse, zero, violation, non-violating pulse is output as eight zeros once its last bit arrives.
- R6: With the effective code bit at 0 and e1_mode at 1 (HDB3), a violation preceded by two zeros is output as zero, together with the three bits before it. This covers both 000V and B00V.
- R7: With chan_ovr_en at 1, chan_code replaces glb_code for this channel. With chan_ovr_en at 0, glb_code decides.
- R8: With dual_rail at 1, rd_data is 0 and glb_code, chan_ovr_en, chan_code and e1_mode have no effect on any output.
- R9: rd_pos and rd_neg carry the raw input rails with the R2 latency in every mode, unaffected by substitution removal.
- R10: Bits that were replaced by zeros no longer count as pulses, violations or zeros of another pattern. Later pattern matching treats them as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies one received bit on this edge |
| pos_in | input | 1 | Positive pulse flag of the bit |
| neg_in | input | 1 | Negative pulse flag of the bit |
| e1_mode | input | 1 | 0 selects B8ZS (T1), 1 selects HDB3 (E1) |
| glb_code | input | 1 | Global code select: 0 substitution decoding, 1 AMI |
| chan_ovr_en | input | 1 | 1 lets chan_code set this channel's rule |
| chan_code | input | 1 | Per-channel code select, same encoding as glb_code |
| dual_rail | input | 1 | 1 bypasses the decoder |
| rd_data | output | 1 | Decoded NRZ data |
| rd_pos | output | 1 | Delayed positive rail |
| rd_neg | output | 1 | Delayed negative rail |

## Verification
Two events can coincide on one enabled edge. A substitution can complete and clear up to eight window bits in the same edge that the oldest symbol leaves the window toward the output. That departing symbol must not be cleared.

The bench provokes this with back-to-back B8ZS patterns and with a pattern that follows straight after a pulse. HDB3 replacements are also run right after earlier replacements, and the bench checks that cleared bits then count as zeros. A behavioural model judges every output bit eight enables later, including the bit that left the window on the clearing edge.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        RULE_B8ZS   = 2'd0,
        RULE_HDB3   = 2'd1,
        RULE_AMI    = 2'd2,
        RULE_BYPASS = 2'd3
    } rule_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_e;

    // one received bit as held in the window
    typedef struct packed {
        logic mk;   // decodes as a one
        logic vi;   // bipolar violation
        logic bi;   // single-rail pulse, not a violation
        logic rp;   // raw positive rail
        logic rn;   // raw negative rail
    } sym_t;

endpackage

// File: rtl/lcd_rule_sel.sv
module lcd_rule_sel
    import lcd_pkg::*;
(
    input  logic  e1_mode,
    input  logic  glb_code,
    input  logic  chan_ovr_en,
    input  logic  chan_code,
    input  logic  dual_rail,
    output rule_e rule
);

    logic eff_code;

    always_comb begin
        eff_code = chan_ovr_en ? chan_code : glb_code;
        unique casez ({dual_rail, eff_code, e1_mode})
            3'b1??:  rule = RULE_BYPASS;
            3'b01?:  rule = RULE_AMI;
            3'b001:  rule = RULE_HDB3;
            default: rule = RULE_B8ZS;
        endcase
    end

endmodule

// File: rtl/lcd_pol_track.sv
module lcd_pol_track
    import lcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic pos_in,
    input  logic neg_in,
    output logic viol
);

    pol_e state, state_nxt;
    logic single;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= POL_NONE;
        else if (bit_en)
            state <= state_nxt;
    end

    always_comb begin
        single    = pos_in ^ neg_in;
        state_nxt = state;
        viol      = 1'b0;
        unique case (state)
            POL_NONE: begin
                if (single) state_nxt = pos_in ? POL_POS : POL_NEG;
            end
            POL_POS: begin
                if (single) begin
                    viol      = pos_in;
                    state_nxt = pos_in ? POL_POS : POL_NEG;
                end
            end
            POL_NEG: begin
                if (single) begin
                    viol      = neg_in;
                    state_nxt = pos_in ? POL_POS : POL_NEG;
                end
            end
            default: state_nxt = POL_NONE;
        endcase
    end

    // R4: a positive-only pulse leaves the tracker in POL_POS
    a_r4_pos_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pos_in && !neg_in) |=> (state == POL_POS));

    // R4: pulses on both rails keep the tracked polarity
    a_r4_both_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pos_in && neg_in) |=> $stable(state));

endmodule

// File: rtl/lcd_window.sv
module lcd_window
    import lcd_pkg::*;
#(
    parameter int DEPTH = 8   // must be at least B8_SPAN
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  rule_e rule,
    input  sym_t  new_sym,
    output sym_t  tail
);

    localparam int B8_SPAN  = 8;
    localparam int HDB_SPAN = 4;

    sym_t win [DEPTH];
    sym_t nxt [DEPTH];
    logic det_b8, det_hdb;

    // window index k holds the bit received k+1 enables before new_sym
    always_comb begin
        det_b8 = (rule == RULE_B8ZS) && new_sym.bi && win[0].vi && !win[1].mk
                 && win[2].bi && win[3].vi && !win[4].mk && !win[5].mk && !win[6].mk;
        det_hdb = (rule == RULE_HDB3) && new_sym.vi && !win[0].mk && !win[1].mk;

        nxt[0] = new_sym;
        for (int k = 1; k < DEPTH; k++)
            nxt[k] = win[k-1];

        if (det_b8) begin
            for (int k = 0; k < B8_SPAN; k++) begin
                nxt[k].mk = 1'b0;
                nxt[k].vi = 1'b0;
                nxt[k].bi = 1'b0;
            end
        end
        if (det_hdb) begin
            for (int k = 0; k < HDB_SPAN; k++) begin
                nxt[k].mk = 1'b0;
                nxt[k].vi = 1'b0;
                nxt[k].bi = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++)
                win[k] <= '0;
        end else if (bit_en) begin
            for (int k = 0; k < DEPTH; k++)
                win[k] <= nxt[k];
        end
    end

    assign tail = win[DEPTH-1];

endmodule

// File: rtl/lcd_decoder.sv
module lcd_decoder
    import lcd_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic pos_in,
    input  logic neg_in,
    input  logic e1_mode,
    input  logic glb_code,
    input  logic chan_ovr_en,
    input  logic chan_code,
    input  logic dual_rail,
    output logic rd_data,
    output logic rd_pos,
    output logic rd_neg
);

    rule_e rule;
    logic  viol;
    sym_t  new_sym, tail;

    lcd_rule_sel u_rule_sel (
        .e1_mode     (e1_mode),
        .glb_code    (glb_code),
        .chan_ovr_en (chan_ovr_en),
        .chan_code   (chan_code),
        .dual_rail   (dual_rail),
        .rule        (rule)
    );

    lcd_pol_track u_pol_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .pos_in (pos_in),
        .neg_in (neg_in),
        .viol   (viol)
    );

    always_comb begin
        new_sym.mk = pos_in | neg_in;
        new_sym.vi = viol;
        new_sym.bi = (pos_in ^ neg_in) & ~viol;
        new_sym.rp = pos_in;
        new_sym.rn = neg_in;
    end

    lcd_window #(.DEPTH(DEPTH)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .rule    (rule),
        .new_sym (new_sym),
        .tail    (tail)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 1'b0;
            rd_pos  <= 1'b0;
            rd_neg  <= 1'b0;
        end else if (bit_en) begin
            rd_data <= (rule == RULE_BYPASS) ? 1'b0 : tail.mk;
            rd_pos  <= tail.rp;
            rd_neg  <= tail.rn;
        end
    end

    // R8: bypass forces the NRZ output low
    a_r8_bypass_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && dual_rail) |=> !rd_data);

    // R2: outputs move only on enabled edges
    a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({rd_data, rd_pos, rd_neg}));

endmodule

// File: tb/lcd_decoder_bench.sv
module lcd_decoder_bench;

    localparam int NMAX = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, pos_in = 1'b0, neg_in = 1'b0;
    logic e1_mode = 1'b0, glb_code = 1'b0, chan_ovr_en = 1'b0, chan_code = 1'b0, dual_rail = 1'b0;
    logic rd_data, rd_pos, rd_neg;

    always #10 clk = ~clk;

    lcd_decoder u_lcd_decoder (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pos_in(pos_in), .neg_in(neg_in),
        .e1_mode(e1_mode), .glb_code(glb_code), .chan_ovr_en(chan_ovr_en),
        .chan_code(chan_code), .dual_rail(dual_rail),
        .rd_data(rd_data), .rd_pos(rd_pos), .rd_neg(rd_neg)
    );

    int checks = 0;
    int errors = 0;
    bit m_mk [NMAX];
    bit m_vi [NMAX];
    bit m_bi [NMAX];
    bit m_rp [NMAX];
    bit m_rn [NMAX];
    int j;
    bit have_pulse, last_pos;

    task automatic check(string r, logic act, logic exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", r, act, exp_v, $time);
        end
    endtask

    task automatic clear_bits(int lo, int hi);
        for (int k = lo; k <= hi; k++) begin
            m_mk[k] = 1'b0; m_vi[k] = 1'b0; m_bi[k] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0;
        for (int k = 0; k < NMAX; k++) begin
            m_mk[k] = 0; m_vi[k] = 0; m_bi[k] = 0; m_rp[k] = 0; m_rn[k] = 0;
        end
        j = 8; have_pulse = 0; last_pos = 0;
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, 1'b0);
        check("R1 rd_pos in reset", rd_pos, 1'b0);
        check("R1 rd_neg in reset", rd_neg, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 1'b0);
    endtask

    // one enabled bit: model the requirements, then compare after the edge
    task automatic send(bit p, bit n, string r);
        int  md;
        bit  single, viol, ed, ep, en;
        @(negedge clk);
        pos_in = p; neg_in = n; bit_en = 1'b1;
        if (dual_rail) md = 3;
        else if (chan_ovr_en ? chan_code : glb_code) md = 2;
        else md = e1_mode ? 1 : 0;
        single = p ^ n;
        viol   = single && have_pulse && (last_pos == p);
        if (single) begin have_pulse = 1; last_pos = p; end
        m_mk[j] = p | n; m_vi[j] = viol; m_bi[j] = single && !viol;
        m_rp[j] = p; m_rn[j] = n;
        if (md == 0 && m_bi[j] && m_vi[j-1] && !m_mk[j-2] && m_bi[j-3] && m_vi[j-4]
            && !m_mk[j-5] && !m_mk[j-6] && !m_mk[j-7])
            clear_bits(j-7, j);
        if (md == 1 && m_vi[j] && !m_mk[j-1] && !m_mk[j-2])
            clear_bits(j-3, j);
        ed = (md == 3) ? 1'b0 : m_mk[j-8];
        ep = m_rp[j-8];
        en = m_rn[j-8];
        j++;
        @(negedge clk);
        bit_en = 1'b0;
        check(r, rd_data, ed);
        check("R9 rd_pos", rd_pos, ep);
        check("R9 rd_neg", rd_neg, en);
    endtask

    task automatic send_str(string s, string r);
        for (int i = 0; i < s.len(); i++) begin
            if (s[i] == "+")      send(1, 0, r);
            else if (s[i] == "-") send(0, 1, r);
            else if (s[i] == "B") send(1, 1, r);
            else                  send(0, 0, r);
        end
    endtask

    task automatic idle_check();
        logic d0, p0, n0;
        @(negedge clk);
        d0 = rd_data; p0 = rd_pos; n0 = rd_neg;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pos_in = i[0]; neg_in = ~i[0];
        end
        @(negedge clk);
        check("R2 rd_data held without bit_en", rd_data, d0);
        check("R2 rd_pos held without bit_en", rd_pos, p0);
        check("R2 rd_neg held without bit_en", rd_neg, n0);
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 / R2 / R3: AMI through the global select
        glb_code = 1'b1;
        do_reset();
        send_str("+000000000", "R2 latency of a single pulse");
        idle_check();
        send_str("+-++--B0+00000-", "R3 AMI passes every pulse");
        send_str("000+-0-+00000000", "R3 AMI keeps B8ZS pattern");

        // R5: B8ZS, back-to-back and opposite polarity, plus a near miss
        glb_code = 1'b0; e1_mode = 1'b0;
        send_str("+000+-0-+000+-0-+", "R5 B8ZS back-to-back");
        send_str("-000-+0+-", "R5 B8ZS negative start");
        send_str("+000+-0+-00000000", "R5 B8ZS near miss kept");
        send_str("+000+-0-+-000-+0+-00000000", "R10 B8ZS chained");

        // R4 / R6: HDB3 from reset, first pulse is not a violation
        e1_mode = 1'b1;
        do_reset();
        send_str("000+000000", "R4 first pulse no violation");
        send_str("-000-+00+0+0+", "R6 HDB3 000V and B00V");
        send_str("000+0+00000000", "R10 HDB3 after cleared bits");
        send_str("+00B0+00000000", "R4 both rails decode as one");

        // R7: override
        chan_ovr_en = 1'b1; chan_code = 1'b0; glb_code = 1'b1;
        send_str("-00-0000-000-00000000", "R7 override selects HDB3");
        chan_code = 1'b1; glb_code = 1'b0;
        send_str("+00+0000000", "R7 override selects AMI");

        // R8: dual rail bypass ignores all code selects
        dual_rail = 1'b1; chan_ovr_en = 1'b0; glb_code = 1'b0; e1_mode = 1'b0;
        send_str("+000+-0-+", "R8 bypass with B8ZS select");
        e1_mode = 1'b1;
        send_str("-00-+B0-000000000", "R8 bypass with HDB3 select");
        dual_rail = 1'b0; e1_mode = 1'b0;
        send_str("00000000", "R2 drain after bypass");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule